// File: doc/BRIEF.md
# Branch Shadow Commit Gate

This block decides which in-flight function units may write their results to the register file while conditional branches are still unresolved. It keeps one shadow bit per function unit per branch slot. When an instruction issues into a unit, that unit records every branch slot that is still open at that moment. From then on the unit is held back from writeback until each of those branches has resolved as correctly predicted.

A branch first claims a slot from the block, which hands out the lowest free index. Later the branch unit reports the outcome as a slot index plus a mispredict flag. A correct outcome clears that slot's column in every row. A mispredict cancels every unit shadowed by the slot: the row and busy flag are cleared and a one-cycle cancel pulse tells the unit to discard its result. Either outcome frees the slot for reuse. Branches may nest, so one row can hold several bits at once.

Nothing in this block reorders or buffers results. It only gates the write port and kills shadowed work in place.

Top module: `shadow_gate`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `pend`, `cancel` and `wr_ok` are all zero and `br_stall` is low.
- R2: An issue (`iss_valid` with unit index `iss_unit`) sets that unit's `busy` bit from the next cycle. Its shadow row is loaded with the slots pending in the issue cycle. A branch slot claimed in that same cycle is not included.
- R3: `wr_ok[u]` is high exactly when unit u is busy, `unit_rdy[u]` is high and its shadow row holds no bits.
- R4: A resolution with `res_valid` high for a pending slot frees that slot: its `pend` bit is low from the next cycle. A correct outcome (`res_miss` = 0) clears that slot's shadow bit in every unit.
- R5: A mispredicted resolution clears the row and the busy bit of every unit shadowed by that slot. It raises `cancel` for exactly those units for exactly one cycle, the cycle after the resolution. Units not shadowed by the slot are unaffected.
- R6: A unit shadowed by several slots keeps `wr_ok` low until every one of those slots has resolved correctly.
- R7: With `br_alloc` high and a free slot, `br_slot` gives the lowest-index slot whose `pend` bit is 0, and that bit is set from the next cycle. With all slots pending, `br_stall` is high in that cycle and nothing is claimed.
- R8: A resolution in the same cycle as an issue is also applied to the incoming row. On a mispredict of a pending slot, the issuing unit is cancelled: `cancel` pulses next cycle and `busy` stays low.
- R9: `wr_ack[u]` clears unit u's busy bit and shadow row from the next cycle.
- R10: A resolution that names a slot which is not pending changes no `pend`, `busy` or `cancel` state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Instruction issues this cycle |
| iss_unit | input | $clog2(NU) | Unit receiving the instruction |
| br_alloc | input | 1 | A branch requests a shadow slot |
| br_slot | output | $clog2(NB) | Slot granted to the branch |
| br_stall | output | 1 | Request made with no free slot |
| res_valid | input | 1 | A branch outcome is reported |
| res_slot | input | $clog2(NB) | Slot of the resolving branch |
| res_miss | input | 1 | 1 = mispredicted, 0 = predicted correctly |
| unit_rdy | input | NU | Per-unit result ready |
| wr_ack | input | NU | Per-unit writeback done |
| wr_ok | output | NU | Per-unit writeback permission |
| cancel | output | NU | Per-unit one-cycle kill pulse |
| busy | output | NU | Per-unit holds an instruction |
| pend | output | NB | Per-slot branch unresolved |

## Verification
The assertions assume a well-behaved issue stage. It never issues into a unit that is already busy or that is being acknowledged in the same cycle. It asserts `wr_ack` only for a unit whose `wr_ok` is high. The random stimulus meets these assumptions by drawing the issue target only from units that the reference model holds idle, and by masking acknowledgements with the model's write permission. Resolutions are allowed to name idle slots on purpose, so that ignored outcomes are covered.

// File: rtl/shadow_gate.sv
module shadow_gate #(
  parameter int NU = 4,
  parameter int NB = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                iss_valid,
  input  logic [(NU > 1 ? $clog2(NU) : 1)-1:0] iss_unit,
  input  logic                                br_alloc,
  output logic [(NB > 1 ? $clog2(NB) : 1)-1:0] br_slot,
  output logic                                br_stall,
  input  logic                                res_valid,
  input  logic [(NB > 1 ? $clog2(NB) : 1)-1:0] res_slot,
  input  logic                                res_miss,
  input  logic [NU-1:0]                       unit_rdy,
  input  logic [NU-1:0]                       wr_ack,
  output logic [NU-1:0]                       wr_ok,
  output logic [NU-1:0]                       cancel,
  output logic [NU-1:0]                       busy,
  output logic [NB-1:0]                       pend
);
  localparam int UW = NU > 1 ? $clog2(NU) : 1;
  localparam int SW = NB > 1 ? $clog2(NB) : 1;

  logic [NB-1:0] pend_q, pend_d, free_v;
  logic [NU-1:0] busy_q, can_q, busy_d, can_d;
  logic [NB-1:0] row_q [NU];
  logic [NB-1:0] row_d [NU];
  logic          res_hit, grant;
  logic [SW-1:0] low_free;

  assign free_v  = ~pend_q;
  assign res_hit = res_valid && pend_q[res_slot];
  assign grant   = br_alloc && (|free_v);

  always_comb begin
    low_free = '0;
    for (int i = NB - 1; i >= 0; i--)
      if (free_v[i]) low_free = SW'(i);
  end

  assign br_slot  = low_free;
  assign br_stall = br_alloc && !(|free_v);

  always_comb begin
    pend_d = pend_q;
    if (res_hit) pend_d[res_slot] = 1'b0;
    if (grant)   pend_d[low_free] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  for (genvar u = 0; u < NU; u++) begin : g_unit
    always_comb begin
      busy_d[u] = busy_q[u];
      row_d[u]  = row_q[u];
      can_d[u]  = 1'b0;
      if (wr_ack[u]) begin
        busy_d[u] = 1'b0;
        row_d[u]  = '0;
      end
      if (iss_valid && iss_unit == UW'(u)) begin
        busy_d[u] = 1'b1;
        row_d[u]  = pend_q;
      end
      if (res_hit) begin
        if (res_miss && row_d[u][res_slot]) begin
          can_d[u]  = 1'b1;
          busy_d[u] = 1'b0;
          row_d[u]  = '0;
        end else begin
          row_d[u][res_slot] = 1'b0;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q[u] <= 1'b0;
        can_q[u]  <= 1'b0;
        row_q[u]  <= '0;
      end else begin
        busy_q[u] <= busy_d[u];
        can_q[u]  <= can_d[u];
        row_q[u]  <= row_d[u];
      end
    end

    assign wr_ok[u] = busy_q[u] && unit_rdy[u] && !(|row_q[u]);

    AST_NO_SHADOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok[u] |-> ((row_q[u] & pend_q) == '0)); // R3
    AST_CANCEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      can_q[u] |-> !busy_q[u]); // R5
    AST_ROW_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (row_q[u] & ~pend_q) == '0); // R4
  end

  assign busy   = busy_q;
  assign cancel = can_q;
  assign pend   = pend_q;

  AST_SLOT_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    br_alloc && !br_stall |=> pend_q[$past(br_slot)]); // R7
  AST_SLOT_FREED: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && pend_q[res_slot] |=> !pend_q[$past(res_slot)]); // R4
  AST_CANCEL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|can_q) |-> $past(res_valid && res_miss)); // R5
  AST_ISSUE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && !(res_valid && res_miss) |=> busy_q[$past(iss_unit)]); // R2
endmodule

// File: tb/sim_shadow_gate.sv
`timescale 1ns/1ps
module sim_shadow_gate;
  logic clk = 0, rst_n = 0;
  logic iss_valid = 0, br_alloc = 0, res_valid = 0, res_miss = 0;
  logic [1:0] iss_unit = 0, res_slot = 0, br_slot;
  logic br_stall;
  logic [3:0] unit_rdy = 0, wr_ack = 0, wr_ok, cancel, busy, pend;
  int n_cmp = 0, n_bad = 0;
  logic [3:0] m_busy = 0, m_pend = 0, m_can = 0;
  logic [3:0] m_row [4] = '{default: 4'h0};

  always #2.5 clk = ~clk;

  shadow_gate u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] model_wr(logic [3:0] rdy);
    logic [3:0] w;
    for (int u = 0; u < 4; u++) w[u] = m_busy[u] && rdy[u] && (m_row[u] == 0);
    return w;
  endfunction

  task automatic cyc(bit iv, int iu, bit ba, bit rv, int rs, bit rm,
                     logic [3:0] rdy, logic [3:0] ack);
    logic [3:0] nb, nc, np, nr [4];
    int slot; bit hit;
    @(negedge clk);
    iss_valid = iv; iss_unit = 2'(iu); br_alloc = ba; res_valid = rv;
    res_slot = 2'(rs); res_miss = rm; unit_rdy = rdy; wr_ack = ack;
    #1;
    slot = -1;
    for (int i = 3; i >= 0; i--) if (!m_pend[i]) slot = i;
    chk("R3 wr_ok", wr_ok, model_wr(rdy));
    chk("R5 cancel", cancel, m_can);
    chk("R2 busy", busy, m_busy);
    chk("R4 pend", pend, m_pend);
    chk("R7 stall", br_stall, ba && slot < 0);
    if (ba && slot >= 0) chk("R7 slot", br_slot, slot);
    hit = rv && m_pend[rs];
    np = m_pend;
    if (hit) np[rs] = 0;
    if (ba && slot >= 0) np[slot] = 1;
    for (int u = 0; u < 4; u++) begin
      nb[u] = m_busy[u]; nr[u] = m_row[u]; nc[u] = 0;
      if (ack[u]) begin nb[u] = 0; nr[u] = 0; end
      if (iv && iu == u) begin nb[u] = 1; nr[u] = m_pend; end
      if (hit) begin
        if (rm && nr[u][rs]) begin nc[u] = 1; nb[u] = 0; nr[u] = 0; end
        else nr[u][rs] = 0;
      end
    end
    @(posedge clk);
    m_busy = nb; m_can = nc; m_pend = np;
    for (int u = 0; u < 4; u++) m_row[u] = nr[u];
    #1;
  endtask

  initial begin
    #100000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 busy", busy, 0); chk("R1 pend", pend, 0);
    chk("R1 cancel", cancel, 0); chk("R1 wr_ok", wr_ok, 0);
    @(negedge clk); rst_n = 1;
    chk("R1 stall", br_stall, 0);
    cyc(1, 3, 0, 0, 0, 0, 4'h0, 4'h0);
    cyc(0, 0, 1, 0, 0, 0, 4'h0, 4'h0);
    chk("R7 slot0 claimed", pend, 4'b0001);
    cyc(1, 0, 1, 0, 0, 0, 4'h0, 4'h0);
    cyc(1, 1, 0, 0, 0, 0, 4'h0, 4'h0);
    chk("R2 busy after issues", busy, 4'b1011);
    cyc(0, 0, 0, 0, 0, 0, 4'hF, 4'h0);
    chk("R3 only unshadowed unit writes", wr_ok, 4'b1000);
    cyc(0, 0, 0, 1, 0, 0, 4'hF, 4'b1000);
    chk("R6 nested unit still held", wr_ok, 4'b0001);
    chk("R9 ack clears busy", busy, 4'b0011);
    chk("R4 slot0 freed", pend, 4'b0010);
    cyc(0, 0, 0, 1, 2, 1, 4'h0, 4'b0001);
    chk("R10 idle slot pend", pend, 4'b0010);
    chk("R10 idle slot cancel", cancel, 4'b0000);
    chk("R10 idle slot busy", busy, 4'b0010);
    cyc(1, 2, 0, 1, 1, 1, 4'h0, 4'h0);
    chk("R8 incoming cancelled", cancel, 4'b0110);
    chk("R8 incoming not busy", busy, 4'b0000);
    cyc(0, 0, 0, 0, 0, 0, 4'h0, 4'h0);
    chk("R5 single-cycle pulse", cancel, 4'b0000);
    for (int k = 0; k < 5; k++) cyc(0, 0, 1, 0, 0, 0, 4'h0, 4'h0);
    chk("R7 all slots pending", pend, 4'b1111);
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1, k, 0, 4'h0, 4'h0);
    chk("R4 all slots freed", pend, 4'b0000);

    void'($urandom(1234));
    for (int n = 0; n < 3000; n++) begin
      bit iv; int iu; logic [3:0] rdy, ack;
      rdy = 4'($urandom);
      ack = 4'($urandom) & model_wr(rdy);
      iv = 0; iu = 0;
      if ($urandom % 3 != 0) begin
        int c = $urandom % 4;
        for (int t = 0; t < 4; t++)
          if (!iv && !m_busy[(c + t) % 4] && !ack[(c + t) % 4]) begin
            iv = 1; iu = (c + t) % 4;
          end
      end
      cyc(iv, iu, ($urandom % 10) < 3, ($urandom % 10) < 3,
          $urandom % 4, $urandom % 2, rdy, ack);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule